// File: doc/BRIEF.md
# Command Descriptor Ring Fetcher

The block follows a circular ring of command descriptors that software builds in host memory and keeps a local descriptor FIFO topped up. Software programs the ring through a small register write port: the base address, the ring size in words, the descriptor format and the fetch configuration. The descriptor format gives the descriptor size, the stride between descriptors and a flag for an extra token-pointer word. The fetch configuration gives the block size and a free-space threshold. Software then announces newly prepared descriptors by adding to a prepared count. The block reports how many descriptors it has taken in through a processed count.

Fetching works in blocks. When the ring holds pending descriptors, the controller picks a block size. This is the smaller of the configured fetch size and the pending count, reduced until one more descriptor would still fit in the FIFO. The controller then waits until the FIFO has room for the whole block and meets the threshold. After that it reads the block one descriptor at a time over a request/response handshake, with one request in flight at a time. The read address is the ring base plus a read pointer. The pointer steps by the stride and returns to zero at the end of the ring.

The controller has five states. IDLE waits for work and checks the format. SIZE trims the block. WAIT waits for FIFO space. REQ presents a request. RECV takes in the response words. The transitions are:
- IDLE to SIZE when enabled with work pending.
- SIZE to WAIT when the block fits, and SIZE to IDLE when not even one descriptor fits.
- WAIT to REQ when space is available, and WAIT to IDLE on disable or when nothing is pending.
- REQ to RECV on acceptance.
- RECV to REQ after each descriptor but the last, and RECV to IDLE after the last.

Top module: `cdr_fetcher`

## Requirements
- R1: After reset, no request or descriptor is presented, both counts read zero, the status reads zero and fetching is disabled.
- R2: While the fetch-size field (register 3, bits 7:0) is zero, no request is issued even with pending descriptors.
- R3: Each request carries address = ring base (register 0) + read pointer and length = descriptor size (register 2, bits 7:0) + token flag (register 2, bit 30). After each descriptor the pointer advances by the stride (register 2, bits 23:16), becomes zero when the sum reaches or passes the ring size (register 1), and then sets status bit 1.
- R4: A block holds min(fetch size, pending) descriptors, reduced until (block + 1) × length ≤ FIFO depth. The largest block is thus the number of whole descriptors that fit, minus one.
- R5: A block starts only when the free FIFO words are at least block × length and at least the threshold (register 3, bits 23:16).
- R6: At most one request is outstanding. The next request comes only after the last response word of the current one, and a presented request holds its address and length until accepted.
- R7: Returned words enter the FIFO and leave on the descriptor port in arrival order, and the FIFO never overflows.
- R8: The processed count increments once per completed descriptor and never passes the prepared count.
- R9: A write to register 4 adds bits 15:0 to the prepared count, or resets it when bit 31 is set. An add that would push the pending count past its range is dropped and sets status bit 3.
- R10: A write to register 5 resets the processed count when bit 0 is set and the read pointer when bit 1 is set.
- R11: Status bit 0 marks a finished block and bit 2 a finished block that left nothing pending. Writing ones to the low five bits of register 6 clears the matching status bits.
- R12: A bad format sets status bit 4 and issues no request. Bad means length zero, stride below length, ring size zero, or one descriptor not fitting beside another in the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| req_valid | output | 1 | Read request presented |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | AW | Read word address |
| req_len | output | 9 | Read length in words |
| rsp_valid | input | 1 | Response word valid |
| rsp_ready | output | 1 | Response word accepted |
| rsp_data | input | DW | Response word |
| desc_valid | output | 1 | Descriptor word available |
| desc_ready | input | 1 | Descriptor word taken |
| desc_data | output | DW | Descriptor word |
| prep_cnt | output | CNT_W | Prepared count |
| proc_cnt | output | CNT_W | Processed count |
| stat | output | 5 | Sticky status bits |

## Verification
The hardest case to reach is a block that has been sized but is held in WAIT. The FIFO is partly full, so the space or threshold test fails even though descriptors are pending. The stimulus reaches it by stalling the descriptor consumer while the prepared count exceeds one block. It then checks that the processed count stops at the first block size, and releases the consumer to let the held block go. A seeded random phase varies size, stride, ring length, block size, threshold and back-pressure on every side. A bench memory model predicts every address, length and descriptor word.

// File: rtl/cdr_fetch_pkg.sv
package cdr_fetch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SIZE = 3'd1,
        ST_WAIT = 3'd2,
        ST_REQ  = 3'd3,
        ST_RECV = 3'd4
    } fetch_state_e;

    localparam int REG_DW = 32;
    localparam int STAT_W = 5;
    localparam int LEN_W  = 9;

    localparam logic [2:0] RA_BASE  = 3'd0;
    localparam logic [2:0] RA_RSIZE = 3'd1;
    localparam logic [2:0] RA_FMT   = 3'd2;
    localparam logic [2:0] RA_FCFG  = 3'd3;
    localparam logic [2:0] RA_PREP  = 3'd4;
    localparam logic [2:0] RA_PROC  = 3'd5;
    localparam logic [2:0] RA_STAT  = 3'd6;

    localparam int SB_BLOCK = 0;
    localparam int SB_WRAP  = 1;
    localparam int SB_DRAIN = 2;
    localparam int SB_OVFL  = 3;
    localparam int SB_FAULT = 4;

    typedef struct packed {
        logic       tok;
        logic [7:0] stride;
        logic [7:0] dsize;
    } desc_fmt_t;

    typedef struct packed {
        logic [7:0] thresh;
        logic [7:0] fsize;
    } fetch_cfg_t;

endpackage

// File: rtl/cdr_regs.sv
module cdr_regs
    import cdr_fetch_pkg::*;
#(
    parameter int AW     = 32,
    parameter int RING_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic              proc_inc,
    input  logic              ev_block,
    input  logic              ev_wrap,
    input  logic              ev_drain,
    input  logic              ev_fault,
    output logic [AW-1:0]     ring_base,
    output logic [RING_W-1:0] ring_size,
    output desc_fmt_t         fmt,
    output fetch_cfg_t        cfg,
    output logic [CNT_W-1:0]  prep_cnt,
    output logic [CNT_W-1:0]  proc_cnt,
    output logic [CNT_W-1:0]  pending,
    output logic              ptr_clr,
    output logic [STAT_W-1:0] stat
);

    logic             wr_base, wr_rsize, wr_fmt, wr_cfg, wr_prep, wr_proc, wr_stat;
    logic [CNT_W:0]   prep_sum;
    logic             prep_ovfl;
    logic [STAT_W-1:0] stat_set, stat_clr;

    always_comb begin
        wr_base  = reg_we && (reg_sel == RA_BASE);
        wr_rsize = reg_we && (reg_sel == RA_RSIZE);
        wr_fmt   = reg_we && (reg_sel == RA_FMT);
        wr_cfg   = reg_we && (reg_sel == RA_FCFG);
        wr_prep  = reg_we && (reg_sel == RA_PREP);
        wr_proc  = reg_we && (reg_sel == RA_PROC);
        wr_stat  = reg_we && (reg_sel == RA_STAT);
    end

    assign pending   = prep_cnt - proc_cnt;
    assign prep_sum  = {1'b0, pending} + {1'b0, reg_wdata[CNT_W-1:0]};
    assign prep_ovfl = prep_sum[CNT_W];
    assign ptr_clr   = wr_proc && reg_wdata[1];

    always_comb begin
        stat_set           = '0;
        stat_set[SB_BLOCK] = ev_block;
        stat_set[SB_WRAP]  = ev_wrap;
        stat_set[SB_DRAIN] = ev_drain;
        stat_set[SB_OVFL]  = wr_prep && !reg_wdata[31] && prep_ovfl;
        stat_set[SB_FAULT] = ev_fault;
        stat_clr           = wr_stat ? reg_wdata[STAT_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_base <= '0;
            ring_size <= '0;
            fmt       <= '0;
            cfg       <= '0;
        end else begin
            if (wr_base)  ring_base <= AW'(reg_wdata);
            if (wr_rsize) ring_size <= reg_wdata[RING_W-1:0];
            if (wr_fmt)   fmt <= '{tok: reg_wdata[30], stride: reg_wdata[23:16], dsize: reg_wdata[7:0]};
            if (wr_cfg)   cfg <= '{thresh: reg_wdata[23:16], fsize: reg_wdata[7:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prep_cnt <= '0;
            proc_cnt <= '0;
            stat     <= '0;
        end else begin
            if (wr_prep) begin
                if (reg_wdata[31])  prep_cnt <= '0;
                else if (!prep_ovfl) prep_cnt <= prep_cnt + reg_wdata[CNT_W-1:0];
            end
            if (wr_proc && reg_wdata[0]) proc_cnt <= '0;
            else if (proc_inc)           proc_cnt <= proc_cnt + CNT_W'(1);
            stat <= (stat & ~stat_clr) | stat_set;
        end
    end

    assert_prep_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_prep && !reg_wdata[31] && prep_ovfl) |=> $stable(prep_cnt))
        else $error("prepared count changed on an overflowing add");

    assert_stat_w1c_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && (reg_wdata[STAT_W-1:0] == '1) && !ev_block && !ev_wrap && !ev_drain && !ev_fault)
        |=> (stat == '0))
        else $error("status not cleared by write of ones");

endmodule

// File: rtl/cdr_fifo.sv
module cdr_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DW-1:0]              wdata,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [DW-1:0]              out_data,
    output logic [$clog2(DEPTH+1)-1:0] level
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          pop;

    assign out_valid = (level != '0);
    assign out_data  = mem[rp];
    assign pop       = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
            if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
            unique case ({push, pop})
                2'b10:   level <= level + CW'(1);
                2'b01:   level <= level - CW'(1);
                default: level <= level;
            endcase
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (level != CW'(DEPTH)))
        else $error("descriptor FIFO written while full");

endmodule

// File: rtl/cdr_fetch_fsm.sv
module cdr_fetch_fsm
    import cdr_fetch_pkg::*;
#(
    parameter int AW     = 32,
    parameter int RING_W = 16,
    parameter int CNT_W  = 16,
    parameter int DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [AW-1:0]              ring_base,
    input  logic [RING_W-1:0]          ring_size,
    input  desc_fmt_t                  fmt,
    input  fetch_cfg_t                 cfg,
    input  logic [CNT_W-1:0]           pending,
    input  logic                       ptr_clr,
    input  logic [$clog2(DEPTH+1)-1:0] fifo_level,
    output logic                       req_valid,
    input  logic                       req_ready,
    output logic [AW-1:0]              req_addr,
    output logic [LEN_W-1:0]           req_len,
    input  logic                       rsp_valid,
    output logic                       rsp_ready,
    output logic                       push,
    output logic                       proc_inc,
    output logic                       ev_block,
    output logic                       ev_wrap,
    output logic                       ev_drain,
    output logic                       ev_fault
);

    localparam int MUL_W = 2 * LEN_W;

    fetch_state_e      state, state_nx;
    logic [7:0]        blk_n, n_left;
    logic [LEN_W-1:0]  cur_len, beat, len_eff;
    logic [RING_W-1:0] rd_ptr;
    logic [RING_W:0]   ptr_sum;
    logic              ptr_wrap, cfg_bad, go, fits, space_ok, beat_last, done_desc;
    logic [7:0]        fetch_n;
    logic [MUL_W-1:0]  need_words, blk_words, free_w, left_words;

    assign len_eff    = {1'b0, fmt.dsize} + {{(LEN_W-1){1'b0}}, fmt.tok};
    assign cfg_bad    = (len_eff == '0) || ({1'b0, fmt.stride} < len_eff) || (ring_size == '0);
    assign go         = (cfg.fsize != 8'd0) && (pending != '0);
    assign fetch_n    = (pending >= CNT_W'(cfg.fsize)) ? cfg.fsize : pending[7:0];
    assign need_words = (MUL_W'(blk_n) + MUL_W'(1)) * MUL_W'(cur_len);
    assign blk_words  = MUL_W'(blk_n) * MUL_W'(cur_len);
    assign left_words = MUL_W'(n_left) * MUL_W'(cur_len);
    assign free_w     = MUL_W'(DEPTH) - MUL_W'(fifo_level);
    assign fits       = need_words <= MUL_W'(DEPTH);
    assign space_ok   = (free_w >= blk_words) && (free_w >= MUL_W'(cfg.thresh));
    assign beat_last  = (beat == cur_len - LEN_W'(1));
    assign ptr_sum    = {1'b0, rd_ptr} + (RING_W+1)'(fmt.stride);
    assign ptr_wrap   = ptr_sum >= {1'b0, ring_size};
    assign done_desc  = (state == ST_RECV) && rsp_valid && beat_last;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (go && !cfg_bad) state_nx = ST_SIZE;
            ST_SIZE: begin
                if (blk_n == 8'd0) state_nx = ST_IDLE;
                else if (fits)     state_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if ((cfg.fsize == 8'd0) || (pending == '0)) state_nx = ST_IDLE;
                else if (space_ok)                          state_nx = ST_REQ;
            end
            ST_REQ:  if (req_ready) state_nx = ST_RECV;
            ST_RECV: begin
                if (done_desc) state_nx = (n_left == 8'd1) ? ST_IDLE : ST_REQ;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_valid = (state == ST_REQ);
        req_addr  = ring_base + AW'(rd_ptr);
        req_len   = cur_len;
        rsp_ready = (state == ST_RECV);
        push      = rsp_ready && rsp_valid;
        proc_inc  = done_desc;
        ev_wrap   = done_desc && ptr_wrap;
        ev_block  = done_desc && (n_left == 8'd1);
        ev_drain  = ev_block && (pending == CNT_W'(1));
        ev_fault  = ((state == ST_IDLE) && go && cfg_bad) || ((state == ST_SIZE) && (blk_n == 8'd0));
    end

    // block bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_n   <= '0;
            n_left  <= '0;
            cur_len <= '0;
            beat    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (go && !cfg_bad) begin
                    blk_n   <= fetch_n;
                    cur_len <= len_eff;
                end
                ST_SIZE: begin
                    if (fits)                n_left <= blk_n;
                    else if (blk_n != 8'd0)  blk_n  <= blk_n - 8'd1;
                end
                ST_REQ:  if (req_ready) beat <= '0;
                ST_RECV: if (rsp_valid) begin
                    if (beat_last) begin
                        beat   <= '0;
                        n_left <= n_left - 8'd1;
                    end else begin
                        beat <= beat + LEN_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // read pointer
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_ptr <= '0;
        else if (ptr_clr)   rd_ptr <= '0;
        else if (done_desc) rd_ptr <= ptr_wrap ? '0 : ptr_sum[RING_W-1:0];
    end

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !ptr_clr) |=> (req_valid && $stable(req_addr) && $stable(req_len)))
        else $error("request dropped or changed before acceptance");

    assert_space_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REQ) |-> (free_w >= left_words))
        else $error("request issued without room for the rest of the block");

    assert_block_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> ((left_words + MUL_W'(cur_len)) <= MUL_W'(DEPTH)))
        else $error("block larger than FIFO capacity minus one descriptor");

    assert_no_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        proc_inc |-> (pending != '0))
        else $error("descriptor completed with nothing pending");

endmodule

// File: rtl/cdr_fetcher.sv
module cdr_fetcher
    import cdr_fetch_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 16,
    parameter int RING_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [AW-1:0]     req_addr,
    output logic [8:0]        req_len,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [DW-1:0]     rsp_data,
    output logic              desc_valid,
    input  logic              desc_ready,
    output logic [DW-1:0]     desc_data,
    output logic [CNT_W-1:0]  prep_cnt,
    output logic [CNT_W-1:0]  proc_cnt,
    output logic [4:0]        stat
);

    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [AW-1:0]     ring_base;
    logic [RING_W-1:0] ring_size;
    desc_fmt_t         fmt;
    fetch_cfg_t        cfg;
    logic [CNT_W-1:0]  pending;
    logic              ptr_clr, push, proc_inc;
    logic              ev_block, ev_wrap, ev_drain, ev_fault;
    logic [LVL_W-1:0]  fifo_level;

    cdr_regs #(.AW(AW), .RING_W(RING_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .proc_inc(proc_inc), .ev_block(ev_block), .ev_wrap(ev_wrap),
        .ev_drain(ev_drain), .ev_fault(ev_fault),
        .ring_base(ring_base), .ring_size(ring_size), .fmt(fmt), .cfg(cfg),
        .prep_cnt(prep_cnt), .proc_cnt(proc_cnt), .pending(pending),
        .ptr_clr(ptr_clr), .stat(stat)
    );

    cdr_fetch_fsm #(.AW(AW), .RING_W(RING_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ring_base(ring_base), .ring_size(ring_size), .fmt(fmt), .cfg(cfg),
        .pending(pending), .ptr_clr(ptr_clr), .fifo_level(fifo_level),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .push(push), .proc_inc(proc_inc),
        .ev_block(ev_block), .ev_wrap(ev_wrap), .ev_drain(ev_drain), .ev_fault(ev_fault)
    );

    cdr_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .wdata(rsp_data),
        .out_valid(desc_valid), .out_ready(desc_ready), .out_data(desc_data),
        .level(fifo_level)
    );

endmodule

// File: tb/cdr_fetcher_tb.sv
module cdr_fetcher_tb;
    import cdr_fetch_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        req_valid, req_ready = 1'b0;
    logic [31:0] req_addr;
    logic [8:0]  req_len;
    logic        rsp_valid = 1'b0, rsp_ready;
    logic [31:0] rsp_data = '0;
    logic        desc_valid, desc_ready = 1'b0;
    logic [31:0] desc_data;
    logic [15:0] prep_cnt, proc_cnt;
    logic [4:0]  stat;

    always #10 clk = ~clk;

    cdr_fetcher u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_data(desc_data),
        .prep_cnt(prep_cnt), .proc_cnt(proc_cnt), .stat(stat)
    );

    int checks = 0, failures = 0;
    bit finished = 0;
    bit stall = 0;
    int rdy_pct = 80;
    int req_seen = 0;
    logic [31:0] exp_q[$];
    logic [31:0] m_base = 0, m_ptr = 0, m_ring = 1, m_stride = 0, m_len = 0;
    bit          rsp_busy = 0;
    logic [31:0] rsp_addr = 0;
    int          rsp_beat = 0, rsp_len = 0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return a ^ {a[15:0], 16'h0} ^ 32'hC3A5_0000;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_fmt(input int sz, input int st, input int tk);
        wr(RA_FMT, {1'b0, tk[0], 6'd0, st[7:0], 8'd0, sz[7:0]});
        m_len = sz + tk; m_stride = st;
    endtask

    task automatic set_ring(input logic [31:0] b, input int sz);
        wr(RA_BASE, b); wr(RA_RSIZE, sz);
        m_base = b; m_ring = sz;
    endtask

    task automatic set_cfg(input int fs, input int th);
        wr(RA_FCFG, {8'd0, th[7:0], 8'd0, fs[7:0]});
    endtask

    task automatic clear_all();
        set_cfg(0, 0);
        wr(RA_PROC, 32'h3);
        wr(RA_PREP, 32'h8000_0000);
        m_ptr = 0;
        wr(RA_STAT, 32'h1F);
    endtask

    task automatic wait_proc(input int target, input string tag);
        int n = 0;
        while (proc_cnt != target[15:0] && n < 5000) begin @(negedge clk); n++; end
        chk(proc_cnt == target[15:0], tag, proc_cnt, target);
    endtask

    task automatic wait_drain(input string tag);
        int n = 0;
        while ((exp_q.size() != 0 || desc_valid) && n < 5000) begin @(negedge clk); n++; end
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    // memory responder, request checker and consumer
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                req_ready = 0; rsp_valid = 0; desc_ready = 0;
            end else begin
                if (rsp_busy) begin
                    rsp_valid = ($urandom % 3) != 0;
                    rsp_data  = mem_word(rsp_addr + rsp_beat);
                    if (rsp_valid && rsp_ready) begin
                        rsp_beat++;
                        if (rsp_beat == rsp_len) rsp_busy = 0;
                    end
                end else begin
                    rsp_valid = 0;
                end
                req_ready = ($urandom % 4) != 0;
                if (req_valid) chk(!rsp_busy, "R6 request while response open", req_valid, 0);
                if (req_valid && req_ready && !rsp_busy) begin
                    chk(req_addr == m_base + m_ptr, "R3 request address", req_addr, m_base + m_ptr);
                    chk(req_len == m_len[8:0], "R3 request length", req_len, m_len);
                    rsp_busy = 1; rsp_addr = m_base + m_ptr; rsp_beat = 0; rsp_len = m_len;
                    for (int k = 0; k < m_len; k++) exp_q.push_back(mem_word(m_base + m_ptr + k));
                    m_ptr = (m_ptr + m_stride >= m_ring) ? 0 : m_ptr + m_stride;
                    req_seen++;
                end
                desc_ready = stall ? 1'b0 : (($urandom % 100) < rdy_pct);
                if (desc_valid && desc_ready) begin
                    if (exp_q.size() == 0) chk(0, "R7 unexpected descriptor word", desc_data, 0);
                    else begin
                        logic [31:0] e;
                        e = exp_q.pop_front();
                        chk(desc_data == e, "R7 descriptor word order", desc_data, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base_req;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!req_valid, "R1 req_valid after reset", req_valid, 0);
        chk(!desc_valid, "R1 desc_valid after reset", desc_valid, 0);
        chk(prep_cnt == 0 && proc_cnt == 0, "R1 counts after reset", {prep_cnt, proc_cnt}, 0);
        chk(stat == 0, "R1 status after reset", stat, 0);

        // R2 disabled while fetch size is zero
        set_ring(32'h0000_1000, 64);
        set_fmt(4, 4, 0);
        wr(RA_PREP, 5);
        repeat (40) @(negedge clk);
        chk(req_seen == 0, "R2 no request while disabled", req_seen, 0);
        chk(proc_cnt == 0, "R2 processed count while disabled", proc_cnt, 0);

        // R4 largest block with consumer stalled: 16-word FIFO, 4-word descriptors -> 3
        stall = 1;
        set_cfg(8, 0);
        repeat (200) @(negedge clk);
        chk(proc_cnt == 3, "R4 block trimmed to fit minus one", proc_cnt, 3);
        chk(exp_q.size() == 12, "R4 words held in FIFO", exp_q.size(), 12);
        chk(desc_valid, "R7 descriptor available", desc_valid, 1);
        stall = 0;
        wait_proc(5, "R8 processed count reaches prepared");
        wait_drain("R7 all words delivered");
        chk(req_seen == 5, "R8 no fetch beyond pending", req_seen, 5);
        chk(stat == 5'b00101, "R11 block and drain status", stat, 5'b00101);
        wr(RA_STAT, 32'h1F);
        chk(stat == 0, "R11 write ones clears status", stat, 0);

        // R3 ring wrap with token word
        clear_all();
        chk(proc_cnt == 0 && prep_cnt == 0, "R10 counts reset", {prep_cnt, proc_cnt}, 0);
        set_ring(32'h0000_2000, 12);
        set_fmt(2, 4, 1);
        set_cfg(2, 0);
        wr(RA_PREP, 7);
        wait_proc(7, "R8 wrap run processed count");
        wait_drain("R7 wrap run words delivered");
        chk(stat[1], "R3 wrap status bit", stat[1], 1);

        // R5 threshold holds a block back
        clear_all();
        set_ring(32'h0000_3000, 64);
        set_fmt(2, 2, 0);
        stall = 1;
        set_cfg(2, 16);
        wr(RA_PREP, 4);
        repeat (150) @(negedge clk);
        chk(proc_cnt == 2, "R5 threshold stops second block", proc_cnt, 2);
        stall = 0;
        wait_proc(4, "R5 second block after drain");
        wait_drain("R7 threshold run words delivered");

        // R12 bad format faults
        clear_all();
        base_req = req_seen;
        set_fmt(2, 1, 0);
        set_cfg(2, 0);
        wr(RA_PREP, 1);
        repeat (20) @(negedge clk);
        chk(stat[4], "R12 stride below size faults", stat[4], 1);
        chk(req_seen == base_req, "R12 no request on bad stride", req_seen, base_req);
        set_fmt(9, 9, 0);
        wr(RA_STAT, 32'h1F);
        repeat (20) @(negedge clk);
        chk(stat[4], "R12 oversize descriptor faults", stat[4], 1);
        chk(req_seen == base_req && proc_cnt == 0, "R12 no fetch on oversize", req_seen, base_req);

        // R9 prepared count overflow rejected
        wr(RA_PREP, 32'h0000_FFFF);
        chk(prep_cnt == 1, "R9 overflowing add dropped", prep_cnt, 1);
        chk(stat[3], "R9 overflow status", stat[3], 1);

        // R10 pointer reset restarts at base
        clear_all();
        set_ring(32'h0000_4000, 64);
        set_fmt(1, 3, 0);
        set_cfg(4, 0);
        wr(RA_PREP, 2);
        wait_proc(2, "R10 run after reset");
        set_cfg(0, 0);
        wr(RA_PROC, 32'h2);
        m_ptr = 0;
        set_cfg(4, 0);
        wr(RA_PREP, 1);
        wait_proc(3, "R10 fetch from ring start after pointer reset");
        wait_drain("R7 pointer reset words delivered");

        // random phase
        for (int r = 0; r < 25; r++) begin
            int sz, tk, st, k, fs, th, p1, p2;
            sz = 1 + $urandom % 4; tk = $urandom % 2;
            st = sz + tk + $urandom % 4; k = 1 + $urandom % 6;
            fs = 1 + $urandom % 6; th = $urandom % 11;
            p1 = 1 + $urandom % 6; p2 = $urandom % 7;
            rdy_pct = 40 + $urandom % 55;
            clear_all();
            set_ring($urandom & 32'hFFFF_FF00, st * k);
            set_fmt(sz, st, tk);
            set_cfg(fs, th);
            wr(RA_PREP, p1);
            if (p2 != 0) wr(RA_PREP, p2);
            wait_proc(p1 + p2, "R8 random round processed count");
            wait_drain("R7 random round words delivered");
        end
        chk(exp_q.size() == 0, "R7 nothing left expected", exp_q.size(), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule